// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

A watchdog timer for a small 8-bit controller. Once running, it counts ticks toward a terminal count picked by a 3-bit rate code. If software does not unlock a restart first, it raises a chip-reset pulse that lasts a fixed number of CPU clocks. A tick is either every DIV-th CPU clock, taken from an internal prescaler, or a cycle in which the slow-oscillator tick input is high. That input is assumed to be synchronised to the CPU clock already.

Software restarts the timer through a feed port using a two-byte key. It first writes 1Eh and later writes E1h. Idle cycles and control-register writes may fall between the two bytes. Any other feed byte written after 1Eh disarms the key. A wrong key has no effect on the running count. A configuration-lock input forces the timer to run from the slow tick, whatever software writes to the control register. A reset-cause input selects the control register's reset value.

Top module: `kfw_watchdog`

## Requirements
- R1: A feed write of 1Eh followed later by a feed write of E1h is a valid feed. Idle cycles and control writes may lie between them. The valid feed clears the count and the prescaler at the E1h write edge, so the next expiry comes a full timeout after that edge.
- R2: A feed write of any byte other than 1Eh disarms the key. An E1h write with no armed key does nothing, and a repeated 1Eh keeps the key armed. A wrong key never moves the scheduled expiry.
- R3: The timeout is (2^BASE_SHIFT << rate) ticks, where rate is control bits 2:0. Expiry happens on the tick that completes that number. With the clock-select bit set, this is DIV*(2^BASE_SHIFT << rate) CPU clocks after the count starts.
- R4: The control register layout is: bit 5 overflow flag, bit 4 run, bit 3 clock select, bits 2:0 rate. Bits 7:6 always read 0. Software writes to bit 5 are ignored.
- R5: The overflow flag (bit 5) is set at expiry and cleared by a valid feed.
- R6: When clock select is 1, a tick occurs every DIV CPU clocks. When it is 0, every cycle in which slow_tick_i is high is a tick.
- R7: While cfg_lock_i is high, the run bit reads 1 and the clock-select bit reads 0, and the timer behaves that way regardless of what software wrote.
- R8: The control register resets to 30h when wd_cause_i is high during reset. Otherwise it resets to 10h when cfg_lock_i is high and to 00h when cfg_lock_i is low.
- R9: wd_rst_o goes high in the cycle after the expiry edge and stays high for exactly PULSE_CYC cycles.
- R10: While the run bit is 0, the count and the prescaler are held at zero, so a restart always gets a full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lock_i | input | 1 | Configuration lock: forces run on and slow-tick clocking |
| wd_cause_i | input | 1 | High when the current reset was caused by the watchdog |
| slow_tick_i | input | 1 | Synchronised slow-oscillator tick |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read value |
| feed_we_i | input | 1 | Feed register write strobe |
| feed_wdata_i | input | 8 | Feed register write data |
| wd_rst_o | output | 1 | Chip-reset pulse |

## Verification
The bench builds the block with BASE_SHIFT=4, DIV=6 and PULSE_CYC=4. With these values, rate 0 expires after 96 CPU clocks and rate 7 after 12,288. Every rate code, including the largest, can therefore be timed cycle-exactly within the run. This also leaves room for several feed, wrong-key and stop/restart patterns, each timed against an expected cycle count. The slow-tick and lock cases hold slow_tick_i high, so one tick arrives per clock and the slow-tick path can be told apart from the divide-by-six path.

// File: rtl/kfw_pkg.sv
// Shared constants and the control register view for the keyed-feed watchdog.
package kfw_pkg;
    localparam logic [7:0] KEY_ARM  = 8'h1E;  // first feed byte
    localparam logic [7:0] KEY_FIRE = 8'hE1;  // second feed byte
    localparam int RATE_W  = 3;
    localparam int OVF_POS = 5;
    localparam int RUN_POS = 4;
    localparam int SEL_POS = 3;

    typedef struct packed {
        logic              ovf;
        logic              run;
        logic              sel;
        logic [RATE_W-1:0] rate;
    } wd_ctrl_t;
endpackage

// File: rtl/kfw_tick_gen.sv
// Tick generator: produces a single-cycle count-enable pulse, either every
// DIV CPU clocks from a local prescaler or from an already synchronised slow
// tick. Assumes DIV >= 2. The prescaler is held at zero while stopped,
// restarted, or unselected, so the tick phase is known after every restart.
module kfw_tick_gen #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic use_div_i,
    input  logic restart_i,
    input  logic slow_tick_i,
    output logic tick_o
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] pre_q;
    logic          wrap;

    assign wrap = (pre_q == PW'(DIV - 1));

    // prescaler: counts CPU clocks modulo DIV while the divided source is in use
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run_i || restart_i || !use_div_i || wrap) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    // tick select: divided clock or slow tick, gated by run and restart
    always_comb begin
        tick_o = run_i && !restart_i && (use_div_i ? wrap : slow_tick_i);
    end
endmodule

// File: rtl/kfw_key_match.sv
// Feed key matcher: arms on a feed write of the first key byte and reports a
// valid feed when the next feed write is the second key byte. Any other feed
// byte disarms the key. Writes on other ports do not touch the armed state.
module kfw_key_match
    import kfw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] data_i,
    output logic       armed_o,
    output logic       feed_ok_o
);
    logic armed_q;

    // armed flag: follows whether the last feed byte was the first key byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_i) begin
            armed_q <= (data_i == KEY_ARM);
        end
    end

    // valid feed detection in the cycle of the second byte's write
    always_comb begin
        feed_ok_o = wr_i && armed_q && (data_i == KEY_FIRE);
        armed_o   = armed_q;
    end
endmodule

// File: rtl/kfw_count_core.sv
// Timeout counter: advances on each tick while running, and expires on the
// tick that completes 2^BASE_SHIFT << rate ticks. It is cleared while
// stopped, on a valid feed and at expiry. A rate lowered mid-count below the
// current value expires on the next tick.
module kfw_count_core #(
    parameter int BASE_SHIFT = 13,
    parameter int RATE_W     = 3,
    parameter int CNT_W      = BASE_SHIFT + (1 << RATE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    // terminal value: one less than the selected timeout length
    always_comb begin
        last_val = (CNT_W'(1) << (BASE_SHIFT + int'(rate_i))) - CNT_W'(1);
        expire_o = tick_i && run_i && !clear_i && (cnt_q >= last_val);
        cnt_o    = cnt_q;
    end

    // tick counter with clear on stop, feed and expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || clear_i || expire_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/kfw_pulse_stretch.sv
// Reset pulse stretcher: turns a single-cycle expiry into a LEN-cycle high
// pulse that starts in the cycle after the expiry edge. Assumes LEN >= 1.
module kfw_pulse_stretch #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int PW = $clog2(LEN + 1);

    logic [PW-1:0] left_q;

    // remaining pulse length: loaded on fire, counted down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (fire_i) begin
            left_q <= PW'(LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - PW'(1);
        end
    end

    // output high while cycles remain
    always_comb begin
        pulse_o = (left_q != '0);
    end
endmodule

// File: rtl/kfw_watchdog.sv
// Keyed-feed watchdog top: holds the control register and wires the tick
// generator, key matcher, timeout counter and reset pulse stretcher.
// Assumes slow_tick_i is synchronous to clk and that wd_cause_i is valid
// while rst_n is low. The lock input overrides the run and clock-select bits
// without changing what software stored.
module kfw_watchdog
    import kfw_pkg::*;
#(
    parameter int BASE_SHIFT = 13,
    parameter int DIV        = 6,
    parameter int PULSE_CYC  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_lock_i,
    input  logic       wd_cause_i,
    input  logic       slow_tick_i,
    input  logic       ctrl_we_i,
    input  logic [7:0] ctrl_wdata_i,
    output logic [7:0] ctrl_rdata_o,
    input  logic       feed_we_i,
    input  logic [7:0] feed_wdata_i,
    output logic       wd_rst_o
);
    localparam int CNT_W = BASE_SHIFT + (1 << RATE_W);

    wd_ctrl_t         ctrl_q;
    logic             run_eff;
    logic             sel_eff;
    logic             tick;
    logic             key_armed;
    logic             feed_ok;
    logic             expire;
    logic [CNT_W-1:0] cnt_q;

    // forced view of run and clock select under the configuration lock
    always_comb begin
        run_eff = ctrl_q.run | cfg_lock_i;
        sel_eff = ctrl_q.sel & ~cfg_lock_i;
    end

    // control register: reset value by cause, software fields, overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.ovf  <= wd_cause_i;
            ctrl_q.run  <= wd_cause_i | cfg_lock_i;
            ctrl_q.sel  <= 1'b0;
            ctrl_q.rate <= '0;
        end else begin
            if (ctrl_we_i) begin
                ctrl_q.run  <= ctrl_wdata_i[RUN_POS];
                ctrl_q.sel  <= ctrl_wdata_i[SEL_POS];
                ctrl_q.rate <= ctrl_wdata_i[RATE_W-1:0];
            end
            if (expire) begin
                ctrl_q.ovf <= 1'b1;
            end else if (feed_ok) begin
                ctrl_q.ovf <= 1'b0;
            end
        end
    end

    // read view: reserved bits zero, forced bits shown as they act
    always_comb begin
        ctrl_rdata_o = {2'b00, ctrl_q.ovf, run_eff, sel_eff, ctrl_q.rate};
    end

    kfw_tick_gen #(
        .DIV (DIV)
    ) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_eff),
        .use_div_i   (sel_eff),
        .restart_i   (feed_ok),
        .slow_tick_i (slow_tick_i),
        .tick_o      (tick)
    );

    kfw_key_match u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (feed_we_i),
        .data_i    (feed_wdata_i),
        .armed_o   (key_armed),
        .feed_ok_o (feed_ok)
    );

    kfw_count_core #(
        .BASE_SHIFT (BASE_SHIFT),
        .RATE_W     (RATE_W),
        .CNT_W      (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_eff),
        .clear_i  (feed_ok),
        .tick_i   (tick),
        .rate_i   (ctrl_q.rate),
        .cnt_o    (cnt_q),
        .expire_o (expire)
    );

    kfw_pulse_stretch #(
        .LEN (PULSE_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (expire),
        .pulse_o (wd_rst_o)
    );
endmodule

// File: rtl/kfw_watchdog_chk.sv
// Property checker for the keyed-feed watchdog, attached by bind below.
// It observes ports plus the key-armed flag and the tick count.
module kfw_watchdog_chk #(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_lock_i,
    input logic             feed_we_i,
    input logic [7:0]       feed_wdata_i,
    input logic [7:0]       ctrl_rdata_o,
    input logic             wd_rst_o,
    input logic             key_armed,
    input logic [CNT_W-1:0] cnt_q
);
    // R1: a valid feed leaves the count at zero
    p_feed_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_we_i && key_armed && feed_wdata_i == 8'hE1) |=> (cnt_q == '0));

    // R2: a feed byte other than the first key byte disarms the key
    p_key_cancel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_we_i && feed_wdata_i != 8'h1E) |=> !key_armed);

    // R4: reserved bits always read zero
    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata_o[7:6] == 2'b00);

    // R5: a valid feed clears the overflow flag
    p_feed_clears_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_we_i && key_armed && feed_wdata_i == 8'hE1) |=> !ctrl_rdata_o[5]);

    // R7: the lock shows run set and slow-tick clocking
    p_lock_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock_i |-> (ctrl_rdata_o[4] && !ctrl_rdata_o[3]));

    // R9: a reset pulse starts together with the overflow flag
    p_pulse_flags_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_o) |-> ctrl_rdata_o[5]);

    // R10: a stopped timer holds the count at zero
    p_stop_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata_o[4] |=> (cnt_q == '0));
endmodule

bind kfw_watchdog kfw_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_lock_i   (cfg_lock_i),
    .feed_we_i    (feed_we_i),
    .feed_wdata_i (feed_wdata_i),
    .ctrl_rdata_o (ctrl_rdata_o),
    .wd_rst_o     (wd_rst_o),
    .key_armed    (key_armed),
    .cnt_q        (cnt_q)
);

// File: tb/kfw_watchdog_bench.sv
`timescale 1ns/1ps
module kfw_watchdog_bench;
    localparam int BS = 4;
    localparam int DV = 6;
    localparam int PL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_lock = 1'b0;
    logic       cause = 1'b0;
    logic       slow = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wd = 8'h00;
    logic [7:0] ctrl_rd;
    logic       feed_we = 1'b0;
    logic [7:0] feed_wd = 8'h00;
    logic       wd_rst;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    kfw_watchdog #(.BASE_SHIFT(BS), .DIV(DV), .PULSE_CYC(PL)) u_kfw_watchdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_lock_i   (cfg_lock),
        .wd_cause_i   (cause),
        .slow_tick_i  (slow),
        .ctrl_we_i    (ctrl_we),
        .ctrl_wdata_i (ctrl_wd),
        .ctrl_rdata_o (ctrl_rd),
        .feed_we_i    (feed_we),
        .feed_wdata_i (feed_wd),
        .wd_rst_o     (wd_rst)
    );

    // expected expiry slot in divided mode: restart slot plus full timeout
    function automatic int exp_div(int rate, int slot);
        return slot + DV * ((1 << BS) << rate) + 1;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset(logic lk, logic cs);
        @(negedge clk);
        rst_n = 1'b0; cfg_lock = lk; cause = cs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ctl_wr(logic [7:0] d);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wd = d;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic feed_wr(logic [7:0] d);
        @(negedge clk); feed_we = 1'b1; feed_wd = d;
        @(negedge clk); feed_we = 1'b0;
    endtask

    // write control value cv at edge E, drive up to three events (port 1 =
    // control, 0 = feed) sampled at E+slot; return the slot index in which
    // the reset pulse is first seen and the pulse width
    task automatic timed_run(logic [7:0] cv,
                             int s1, logic p1, logic [7:0] d1,
                             int s2, logic p2, logic [7:0] d2,
                             int s3, logic p3, logic [7:0] d3,
                             output int t, output int w);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wd = cv;
        t = -1; w = 0;
        for (int c = 1; c <= 20000; c++) begin
            @(negedge clk);
            ctrl_we = 1'b0; feed_we = 1'b0;
            if (wd_rst) begin t = c; break; end
            if (c == s1) begin if (p1) begin ctrl_we = 1'b1; ctrl_wd = d1; end else begin feed_we = 1'b1; feed_wd = d1; end end
            if (c == s2) begin if (p2) begin ctrl_we = 1'b1; ctrl_wd = d2; end else begin feed_we = 1'b1; feed_wd = d2; end end
            if (c == s3) begin if (p3) begin ctrl_we = 1'b1; ctrl_wd = d3; end else begin feed_we = 1'b1; feed_wd = d3; end end
        end
        ctrl_we = 1'b0; feed_we = 1'b0;
        if (t > 0) begin
            w = 1;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (wd_rst) w++; else break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t, w, e;
        void'($urandom(32'd4242));

        // R8: reset values by cause and lock
        do_reset(1'b0, 1'b0);
        check(ctrl_rd == 8'h00, "R8 plain reset", ctrl_rd, 8'h00);
        do_reset(1'b1, 1'b0);
        check(ctrl_rd == 8'h10, "R8 locked reset", ctrl_rd, 8'h10);
        do_reset(1'b0, 1'b1);
        check(ctrl_rd == 8'h30, "R8 watchdog-cause reset", ctrl_rd, 8'h30);

        // R5: feed clears overflow left by the watchdog-cause reset
        feed_wr(8'h1E); feed_wr(8'hE1);
        check(ctrl_rd == 8'h10, "R5 feed clears ovf", ctrl_rd, 8'h10);
        // R4: reserved and overflow bits ignore writes
        ctl_wr(8'hFF);
        check(ctrl_rd == 8'h1F, "R4 write masks", ctrl_rd, 8'h1F);
        ctl_wr(8'h00);
        check(ctrl_rd == 8'h00, "R4 stop readback", ctrl_rd, 8'h00);

        // R3 R9 R5: divided-clock timeout, pulse width, overflow set
        timed_run(8'h18, 0,0,0, 0,0,0, 0,0,0, t, w);
        check(t == exp_div(0, 0), "R3 rate0 timeout", t, exp_div(0, 0));
        check(w == PL, "R9 pulse width", w, PL);
        check(ctrl_rd[5] == 1'b1, "R5 ovf after expiry", ctrl_rd[5], 1);
        ctl_wr(8'h00);

        timed_run(8'h1F, 0,0,0, 0,0,0, 0,0,0, t, w);
        check(t == exp_div(7, 0), "R3 rate7 timeout", t, exp_div(7, 0));
        ctl_wr(8'h00);

        // R1: split key with a control write between the bytes
        timed_run(8'h19, 50,0,8'h1E, 60,1,8'h19, 100,0,8'hE1, t, w);
        check(t == exp_div(1, 100), "R1 split feed", t, exp_div(1, 100));
        check(ctrl_rd[5] == 1'b1, "R5 ovf set again", ctrl_rd[5], 1);
        ctl_wr(8'h00);

        // R2: wrong middle byte, lone second byte, repeated first byte
        timed_run(8'h19, 30,0,8'h1E, 40,0,8'h55, 60,0,8'hE1, t, w);
        check(t == exp_div(1, 0), "R2 wrong key keeps schedule", t, exp_div(1, 0));
        ctl_wr(8'h00);
        timed_run(8'h19, 30,0,8'hE1, 0,0,0, 0,0,0, t, w);
        check(t == exp_div(1, 0), "R2 lone second byte", t, exp_div(1, 0));
        ctl_wr(8'h00);
        timed_run(8'h19, 20,0,8'h1E, 40,0,8'h1E, 60,0,8'hE1, t, w);
        check(t == exp_div(1, 60), "R2 repeated first byte", t, exp_div(1, 60));
        ctl_wr(8'h00);

        // R10: stop mid-count then restart gets a full timeout
        timed_run(8'h19, 20,1,8'h09, 30,1,8'h19, 0,0,0, t, w);
        check(t == exp_div(1, 30), "R10 stop and restart", t, exp_div(1, 30));
        ctl_wr(8'h00);

        // R6: slow tick high every cycle with clock select 0
        slow = 1'b1;
        timed_run(8'h11, 0,0,0, 0,0,0, 0,0,0, t, w);
        check(t == 33, "R6 slow tick timeout", t, 33);
        ctl_wr(8'h00);
        slow = 1'b0;

        // R7: lock forces run and slow-tick clocking
        do_reset(1'b1, 1'b0);
        ctl_wr(8'h0A);
        check(ctrl_rd == 8'h12, "R7 forced readback", ctrl_rd, 8'h12);
        slow = 1'b1;
        timed_run(8'h0A, 1,0,8'h1E, 2,0,8'hE1, 0,0,0, t, w);
        check(t == 2 + 64 + 1, "R7 forced slow clocking", t, 67);
        slow = 1'b0;
        do_reset(1'b0, 1'b0);

        // R1 R2 R3: constrained random feed patterns
        for (int i = 0; i < 8; i++) begin
            int rate, mode, a, b;
            logic [7:0] junk;
            rate = int'($urandom % 4);
            mode = int'($urandom % 3);
            a = 1 + int'($urandom % 40);
            b = a + 1 + int'($urandom % 40);
            junk = 8'($urandom);
            if (junk == 8'h1E || junk == 8'hE1) junk = 8'h00;
            case (mode)
                0: begin
                    timed_run(8'h18 | 8'(rate), 0,0,0, 0,0,0, 0,0,0, t, w);
                    e = exp_div(rate, 0);
                    check(t == e, "R3 random no feed", t, e);
                end
                1: begin
                    timed_run(8'h18 | 8'(rate), a,0,8'h1E, b,0,junk, b+5,0,8'hE1, t, w);
                    e = exp_div(rate, 0);
                    check(t == e, "R2 random wrong key", t, e);
                end
                default: begin
                    timed_run(8'h18 | 8'(rate), a,0,8'h1E, b,0,8'hE1, 0,0,0, t, w);
                    e = exp_div(rate, b);
                    check(t == e, "R1 random valid feed", t, e);
                end
            endcase
            ctl_wr(8'h00);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule